// File: doc/BRIEF.md
# Radix-4 Partial Remainder Step

This block is one combinational step of a digit-serial modular reduction. It takes a partial remainder that is already below the modulus, shifts it left by two places, and places the next two bits of the number being reduced below it. The result is the step operand Ai = 4·R + d. The step then brings Ai back below the modulus P by removing none, one, two or three copies of P. A reduction of a 2N-bit number by an N-bit modulus chains N/2 of these steps. The first step receives the upper N bits of the number, and each later step receives its own pair of lower bits.

The caller supplies the multiples P, 2P and 3P, already formed. The step uses two magnitude comparators that work side by side. One always tests Ai against 2P. The outcome of that test picks the second comparator's reference: 3P when Ai ≥ 2P, and P otherwise. The two comparison outcomes name the multiple to remove. A single adder then removes it by adding the one's complement of that multiple with a carry-in of one. When no multiple is needed, the adder's second operand and its carry-in are both held at zero. The step also reports which multiple it chose.

Top module: `radix4_rem_step`

## Requirements
- R1: The step operand is Ai = 4·rem_prev + digit, where digit bit 1 has weight 2 and digit bit 0 has weight 1.
- R2: When Ai < P, mul_code is 0 and rem_out equals Ai.
- R3: When P ≤ Ai < 2P, mul_code is 1 and rem_out equals Ai − P.
- R4: When 2P ≤ Ai < 3P, mul_code is 2 and rem_out equals Ai − 2P.
- R5: When Ai ≥ 3P, mul_code is 3 and rem_out equals Ai − 3P.
- R6: For every P ≥ 1 and every rem_prev < P, rem_out is below P. At each exact boundary (Ai = P, 2P or 3P) the higher multiple is chosen and rem_out is 0.
- R7: mul_code is the count of moduli removed, so Ai = rem_out + mul_code·P holds for every legal input.
- R8: The internal sum is W+2 bits wide and its bits above W−1 are zero for every legal input, up to the largest modulus 2^W − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rem_prev | input | W | Previous partial remainder; the caller keeps it below P |
| digit | input | 2 | Next two bits of the number being reduced |
| mul1 | input | W | The modulus P |
| mul2 | input | W+1 | 2P, precomputed by the caller |
| mul3 | input | W+2 | 3P, precomputed by the caller |
| rem_out | output | W | New partial remainder Ai mod P |
| mul_code | output | 2 | Multiple removed: 0 none, 1 P, 2 2P, 3 3P |

## Verification
The bench builds the step with W = 8.

With this width, every modulus from 1 to 31 can be swept in full. The sweep covers every legal remainder and every digit, which reaches each of the four selection outcomes and each exact boundary at P, 2P and 3P. At the same width, the largest modulus 255 pushes Ai to 1019. That value exercises the top of the W+2-bit sum. Random moduli across the full 8-bit range and a short worked chain with P = 35 complete the stimulus.

// File: rtl/radix4_rem_pkg.sv
package radix4_rem_pkg;

  typedef enum logic [1:0] {
    MUL_NONE  = 2'd0,
    MUL_ONE   = 2'd1,
    MUL_TWO   = 2'd2,
    MUL_THREE = 2'd3
  } mul_sel_e;

  // Turn the two comparator outcomes into the multiple to remove.
  // ge_2p: operand >= 2P. ge_alt: operand >= (ge_2p ? 3P : P).
  function automatic mul_sel_e pick_multiple(input logic ge_2p, input logic ge_alt);
    if (ge_2p) return ge_alt ? MUL_THREE : MUL_TWO;
    else       return ge_alt ? MUL_ONE   : MUL_NONE;
  endfunction

endpackage

// File: rtl/rem_cmp_ge.sv
module rem_cmp_ge #(
  parameter int WIDTH = 10
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output logic             ge
);
  assign ge = (lhs >= rhs);
endmodule

// File: rtl/rem_mux2.sv
module rem_mux2 #(
  parameter int WIDTH = 10
) (
  input  logic             pick_hi,
  input  logic [WIDTH-1:0] lo,
  input  logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] y
);
  assign y = pick_hi ? hi : lo;
endmodule

// File: rtl/rem_csub.sv
// Subtraction through the one's complement and a carry-in.
// When en is low, both the complement and the carry-in are held at zero.
module rem_csub #(
  parameter int WIDTH = 10
) (
  input  logic [WIDTH-1:0] minuend,
  input  logic [WIDTH-1:0] subtrahend,
  input  logic             en,
  output logic [WIDTH-1:0] diff
);
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] carry_in;

  assign addend   = en ? ~subtrahend : '0;
  assign carry_in = {{(WIDTH-1){1'b0}}, en};
  assign diff     = minuend + addend + carry_in;
endmodule

// File: rtl/radix4_rem_step.sv
module radix4_rem_step
  import radix4_rem_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] rem_prev,
  input  logic [1:0]   digit,
  input  logic [W-1:0] mul1,
  input  logic [W:0]   mul2,
  input  logic [W+1:0] mul3,
  output logic [W-1:0] rem_out,
  output logic [1:0]   mul_code
);
  localparam int AW = W + 2;

  // Named internal events, kept visible for the checker.
  logic [AW-1:0] ai_val;
  logic [AW-1:0] m1x, m2x, m3x;
  logic [AW-1:0] alt_rhs;
  logic [AW-1:0] sub_val;
  logic [AW-1:0] sum_val;
  logic          ge_2p;
  logic          ge_alt;
  logic          sub_en;
  mul_sel_e      code;

  assign ai_val = {rem_prev, digit};
  assign m1x    = {2'b00, mul1};
  assign m2x    = {1'b0, mul2};
  assign m3x    = mul3;

  // First comparator: always against 2P.
  rem_cmp_ge #(.WIDTH(AW)) u_cmp_2p (
    .lhs(ai_val), .rhs(m2x), .ge(ge_2p)
  );

  // Reference for the second comparator, chosen by the first outcome.
  rem_mux2 #(.WIDTH(AW)) u_alt_mux (
    .pick_hi(ge_2p), .lo(m1x), .hi(m3x), .y(alt_rhs)
  );

  rem_cmp_ge #(.WIDTH(AW)) u_cmp_alt (
    .lhs(ai_val), .rhs(alt_rhs), .ge(ge_alt)
  );

  assign code = pick_multiple(ge_2p, ge_alt);

  always_comb begin
    unique case (code)
      MUL_ONE:   sub_val = m1x;
      MUL_TWO:   sub_val = m2x;
      MUL_THREE: sub_val = m3x;
      default:   sub_val = '0;
    endcase
  end

  assign sub_en = (code != MUL_NONE);

  rem_csub #(.WIDTH(AW)) u_sub (
    .minuend(ai_val), .subtrahend(sub_val), .en(sub_en), .diff(sum_val)
  );

  assign rem_out  = sum_val[W-1:0];
  assign mul_code = code;
endmodule

// File: rtl/radix4_rem_step_chk.sv
module radix4_rem_step_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] rem_prev,
  input logic [W-1:0] mul1,
  input logic [W:0]   mul2,
  input logic [W+1:0] mul3,
  input logic [W-1:0] rem_out,
  input logic [1:0]   mul_code,
  input logic [W+1:0] ai_val,
  input logic [W+1:0] sum_val,
  input logic         ge_2p,
  input logic         sub_en
);
  localparam int XW = W + 4;

  logic          legal;
  logic [XW-1:0] ai_x, p_x, recon;

  always_comb begin
    legal = (mul1 != '0) && (rem_prev < mul1)
            && ({1'b0, mul2} == ({2'b00, mul1} << 1))
            && (mul3 == ({2'b00, mul1} + ({2'b00, mul1} << 1)));
    ai_x  = {2'b00, ai_val};
    p_x   = {4'b0000, mul1};
    recon = {4'b0000, rem_out} + ({{(XW-2){1'b0}}, mul_code} * p_x);

    if (legal) begin
      // R6: the result is always below the modulus
      a_r6_below_p: assert (rem_out < mul1)
        else $error("rem_out %0d not below P %0d", rem_out, mul1);
      // R7: the removed count and the result rebuild the operand (R1 operand)
      a_r7_reconstruct: assert (recon == ai_x)
        else $error("rebuild %0d != operand %0d", recon, ai_x);
      // R8: the bits of the sum above W-1 stay clear
      a_r8_no_overflow: assert (sum_val[W+1:W] == 2'b00)
        else $error("sum high bits set: %0d", sum_val);
      // R4: the 2P comparator decides the upper code bit
      a_r4_upper_bit: assert (ge_2p == mul_code[1])
        else $error("ge_2p %0d vs code %0d", ge_2p, mul_code);
      // R2: pass-through means no subtraction and an operand below P
      a_r2_pass: assert ((mul_code != 2'd0) || (!sub_en && ai_x < p_x))
        else $error("pass-through with operand %0d", ai_x);
      // R5: code 3 only at or above 3P
      a_r5_three: assert ((mul_code != 2'd3) || (ai_val >= mul3))
        else $error("code 3 with operand %0d below 3P", ai_val);
      // R3: code 1 only inside [P, 2P)
      a_r3_one: assert ((mul_code != 2'd1) || (ai_x >= p_x && ai_val < {1'b0, mul2}))
        else $error("code 1 with operand %0d", ai_val);
    end
  end
endmodule

bind radix4_rem_step radix4_rem_step_chk #(.W(W)) u_chk (
  .rem_prev(rem_prev), .mul1(mul1), .mul2(mul2), .mul3(mul3),
  .rem_out(rem_out), .mul_code(mul_code), .ai_val(ai_val),
  .sum_val(sum_val), .ge_2p(ge_2p), .sub_en(sub_en)
);

// File: tb/sim_radix4_rem_step.sv
module sim_radix4_rem_step;
  localparam int W  = 8;
  localparam int W1 = W + 1;
  localparam int W2 = W + 2;

  logic          clk = 1'b0;
  logic [W-1:0]  rem_prev = '0;
  logic [1:0]    digit = '0;
  logic [W-1:0]  mul1 = '0;
  logic [W:0]    mul2 = '0;
  logic [W+1:0]  mul3 = '0;
  logic [W-1:0]  rem_out;
  logic [1:0]    mul_code;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  radix4_rem_step #(.W(W)) u0 (
    .rem_prev(rem_prev), .digit(digit), .mul1(mul1), .mul2(mul2),
    .mul3(mul3), .rem_out(rem_out), .mul_code(mul_code)
  );

  function automatic int ref_rem(input int a, input int p);
    return a % p;
  endfunction

  function automatic int ref_count(input int a, input int p);
    return a / p;
  endfunction

  function automatic string tag_for(input int cnt);
    case (cnt)
      0:       return "R2";
      1:       return "R3";
      2:       return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int r, input int d, input int p);
    int a, er, ec;
    @(negedge clk);
    rem_prev = r[W-1:0];
    digit    = d[1:0];
    mul1     = p[W-1:0];
    mul2     = W1'(2 * p);
    mul3     = W2'(3 * p);
    #2;
    a  = 4 * r + d;
    er = ref_rem(a, p);
    ec = ref_count(a, p);
    check(tag_for(ec), int'(rem_out), er);
    check(tag_for(ec), int'(mul_code), ec);
    check("R6", int'(rem_out < mul1), 1);
    check("R7", int'(rem_out) + int'(mul_code) * p, a);
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // Idle-state vector: zero remainder, zero digit, P = 1
    apply(0, 0, 1);

    // R1: digit weights seen through pass-through with a large modulus
    apply(0, 2, 200);
    check("R1", int'(rem_out), 2);
    apply(1, 1, 200);
    check("R1", int'(rem_out), 5);

    // Worked chain with P = 35 (R4, R3)
    apply(22, 1, 35);
    check("R4", int'(rem_out), 19);
    apply(19, 3, 35);
    check("R4", int'(rem_out), 9);
    apply(9, 1, 35);
    check("R3", int'(rem_out), 2);

    // R6: exact boundaries pick the higher multiple
    apply(8, 3, 35);   check("R6", int'(mul_code), 1);
    apply(17, 2, 35);  check("R6", int'(mul_code), 2);
    apply(26, 1, 35);  check("R6", int'(mul_code), 3);
    apply(8, 2, 35);   check("R2", int'(rem_out), 34);

    // R8: largest modulus, largest operand
    apply(254, 3, 255);
    check("R8", int'(rem_out), 254);
    check("R8", int'(mul_code), 3);
    apply(0, 3, 1);
    check("R5", int'(mul_code), 3);

    // Full sweep of small moduli
    for (int p = 1; p <= 31; p++)
      for (int r = 0; r < p; r++)
        for (int d = 0; d < 4; d++)
          apply(r, d, p);

    // Random over the full range
    for (int k = 0; k < 3000; k++) begin
      int p, r, d;
      p = int'($urandom % 255) + 1;
      r = int'($urandom % p);
      d = int'($urandom % 4);
      apply(r, d, p);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule